// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block turns one received rate-1/3 symbol into branch metrics for a Viterbi trellis. The symbol arrives as three signed soft samples, each a small two's complement value. For each of the eight possible 3-bit branch labels, the unit adds a sample where the label bit is 0 and subtracts it where the label bit is 1. The result is a set of eight signed metrics. A received value near -3 stands for a transmitted 0 and a value near +3 for a transmitted 1, so a smaller metric means a closer match between the received samples and the label.

The metrics are registered and appear one clock after a valid sample triple. When the serial option is built in, the same registered word is also loaded into eight parallel shift lanes. Each lane carries one metric, least significant bit first, to a bit-serial add-compare-select datapath. A strobe marks the first bit of every frame.

Top module: `softdec_branch_metric`

## Requirements
- R1: While reset is asserted and right after it, par_valid, ser_valid and ser_first are 0, and par_metrics is all zeros.
- R2: A sample equal to the most negative code (3'b100, -4) is used as -3.
- R3: Sample j sits in samples_i[3j+2:3j]. Metric k (label index 0..7) sits in par_metrics[5k+4:5k] as 5-bit two's complement. It is the sum over j of +sample j when bit (2-j) of k is 0, and -sample j when that bit is 1. For example, k=2 (label 010) gives i0 - i1 + i2.
- R4: With all three samples at -3, metric 0 is -9 and metric 7 is +9.
- R5: The par_valid output pulses for exactly one cycle, one clock after a cycle in which in_valid is high. par_metrics updates at that same edge.
- R6: Samples presented while in_valid is low change neither par_metrics nor par_valid.
- R7: The clock after par_valid, a serial frame starts. For 5 cycles ser_valid is 1 and ser_bits[k] carries metric k, LSB first. ser_first is 1 only on the first bit. ser_valid returns to 0 on the sixth cycle unless a new frame starts.
- R8: A new par_valid during a running frame aborts that frame: the next cycle starts the new word's frame, with ser_first set.
- R9: Metrics of complementary labels (k and 7-k) are always negatives of each other.
- R10: When every sample is exactly -3 for a label bit 0 and +3 for a label bit 1, that label's metric is -9. Every other metric is strictly larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample triple on samples_i is valid this cycle |
| samples_i | input | 9 | Three 3-bit two's complement soft samples, sample j at [3j+2:3j] |
| par_valid | output | 1 | One-cycle strobe: par_metrics holds a new word |
| par_metrics | output | 40 | Eight 5-bit signed metrics, metric k at [5k+4:5k] |
| ser_valid | output | 1 | ser_bits carries a metric bit this cycle |
| ser_first | output | 1 | This is bit 0 (LSB) of a serial frame |
| ser_bits | output | 8 | One serial lane per metric, lane k carries metric k |

## Verification
Two functions can fall in the same cycle: capturing a fresh parallel word, and shifting out a frame that is still in progress. The bench provokes this by presenting a second sample triple two cycles after the first. The first frame's second bit and the second word's par_valid then coincide. The bench expects the old frame's bit 1 with ser_first low in that cycle, followed by a complete frame of the new word starting with ser_first high. Random and directed triples, including the -4 code and the exact-match label patterns, are compared with a bench function that applies the add/subtract rule.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

   // Smallest metric width that holds n samples of sw bits summed with signs.
   function automatic int unsigned min_metric_w(int unsigned sw, int unsigned n);
      return sw + $clog2(n + 1);
   endfunction

   // Largest magnitude of one sample after saturation.
   function automatic int sample_peak(int unsigned sw);
      return (1 << (sw - 1)) - 1;
   endfunction

endpackage

// File: rtl/sample_clamp.sv
module sample_clamp #(
   parameter int unsigned SAMPLE_W = 3
) (
   input  logic [SAMPLE_W-1:0] raw_i,
   output logic [SAMPLE_W-1:0] sat_o
);

   localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

   // The asymmetric code is pulled in by one so that negation never overflows.
   always_comb begin
      if (raw_i == MOST_NEG) begin
         sat_o = raw_i + SAMPLE_W'(1);
      end else begin
         sat_o = raw_i;
      end
   end

endmodule

// File: rtl/label_metric_gen.sv
module label_metric_gen #(
   parameter int unsigned N_SAMP   = 3,
   parameter int unsigned SAMPLE_W = 3,
   parameter int unsigned METRIC_W = 5
) (
   input  logic [N_SAMP*SAMPLE_W-1:0]         samp_i,
   output logic [(1<<N_SAMP)*METRIC_W-1:0]    metric_o
);

   localparam int unsigned LABELS = 1 << N_SAMP;
   localparam int unsigned EXT_W  = METRIC_W - SAMPLE_W;

   // Sign-extend each sample once, shared by every label.
   logic signed [METRIC_W-1:0] ext [N_SAMP];

   for (genvar j = 0; j < N_SAMP; j++) begin : g_ext
      assign ext[j] = {{EXT_W{samp_i[j*SAMPLE_W+SAMPLE_W-1]}}, samp_i[j*SAMPLE_W +: SAMPLE_W]};
   end

   for (genvar k = 0; k < LABELS; k++) begin : g_label
      localparam int unsigned LBL = k;
      logic signed [METRIC_W-1:0] acc;

      always_comb begin
         acc = '0;
         for (int j = 0; j < N_SAMP; j++) begin
            // Label bit (N_SAMP-1-j) steers sample j: 0 adds, 1 subtracts.
            if (((LBL >> (N_SAMP - 1 - j)) & 1) != 0) begin
               acc = acc - ext[j];
            end else begin
               acc = acc + ext[j];
            end
         end
      end

      assign metric_o[k*METRIC_W +: METRIC_W] = acc;
   end

endmodule

// File: rtl/metric_serializer.sv
module metric_serializer #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned METRIC_W = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_i,
   input  logic [LANES*METRIC_W-1:0]   word_i,
   output logic [LANES-1:0]            bits_o,
   output logic                        first_o,
   output logic                        valid_o
);

   localparam int unsigned CNT_W = $clog2(METRIC_W + 1);

   logic [METRIC_W-1:0] shreg [LANES];
   logic [CNT_W-1:0]    left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LANES; l++) begin
            shreg[l] <= '0;
         end
         bits_o  <= '0;
         left_q  <= '0;
         first_o <= 1'b0;
         valid_o <= 1'b0;
      end else if (load_i) begin
         // A new word always wins, even over a frame still in flight.
         for (int l = 0; l < LANES; l++) begin
            bits_o[l] <= word_i[l*METRIC_W];
            shreg[l]  <= word_i[l*METRIC_W +: METRIC_W] >> 1;
         end
         left_q  <= CNT_W'(METRIC_W - 1);
         first_o <= 1'b1;
         valid_o <= 1'b1;
      end else if (left_q != '0) begin
         for (int l = 0; l < LANES; l++) begin
            bits_o[l] <= shreg[l][0];
            shreg[l]  <= shreg[l] >> 1;
         end
         left_q  <= left_q - CNT_W'(1);
         first_o <= 1'b0;
      end else begin
         bits_o  <= '0;
         first_o <= 1'b0;
         valid_o <= 1'b0;
      end
   end

   // R7
   first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_o |-> valid_o);

   // R8
   frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (first_o && valid_o));

   // R7
   frame_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !first_o) |-> $past(valid_o));

endmodule

// File: rtl/softdec_branch_metric.sv
module softdec_branch_metric #(
   parameter int unsigned N_SAMP    = 3,
   parameter int unsigned SAMPLE_W  = 3,
   parameter int unsigned METRIC_W  = 5,
   parameter bit          SERIAL_EN = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [N_SAMP*SAMPLE_W-1:0]           samples_i,
   output logic                                 par_valid,
   output logic [(1<<N_SAMP)*METRIC_W-1:0]      par_metrics,
   output logic                                 ser_valid,
   output logic                                 ser_first,
   output logic [(1<<N_SAMP)-1:0]               ser_bits
);

   localparam int unsigned LABELS = 1 << N_SAMP;
   localparam int unsigned WORD_W = LABELS * METRIC_W;
   localparam int          PEAK   = N_SAMP * bmu_pkg::sample_peak(SAMPLE_W);

   if (SAMPLE_W < 2) begin : g_bad_sw
      $error("SAMPLE_W must be at least 2");
   end
   if (N_SAMP < 1) begin : g_bad_n
      $error("N_SAMP must be at least 1");
   end
   if (METRIC_W < bmu_pkg::min_metric_w(SAMPLE_W, N_SAMP)) begin : g_bad_mw
      $error("METRIC_W too narrow for the signed sum");
   end

   logic [N_SAMP*SAMPLE_W-1:0] sat;
   logic [WORD_W-1:0]          metric_d;

   for (genvar j = 0; j < N_SAMP; j++) begin : g_clamp
      sample_clamp #(.SAMPLE_W(SAMPLE_W)) u_clamp (
         .raw_i (samples_i[j*SAMPLE_W +: SAMPLE_W]),
         .sat_o (sat[j*SAMPLE_W +: SAMPLE_W])
      );
   end

   label_metric_gen #(
      .N_SAMP   (N_SAMP),
      .SAMPLE_W (SAMPLE_W),
      .METRIC_W (METRIC_W)
   ) u_gen (
      .samp_i   (sat),
      .metric_o (metric_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_valid   <= 1'b0;
         par_metrics <= '0;
      end else begin
         par_valid <= in_valid;
         if (in_valid) begin
            par_metrics <= metric_d;
         end
      end
   end

   if (SERIAL_EN) begin : g_serial
      metric_serializer #(
         .LANES    (LABELS),
         .METRIC_W (METRIC_W)
      ) u_ser (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (par_valid),
         .word_i  (par_metrics),
         .bits_o  (ser_bits),
         .first_o (ser_first),
         .valid_o (ser_valid)
      );
   end else begin : g_no_serial
      assign ser_bits  = '0;
      assign ser_first = 1'b0;
      assign ser_valid = 1'b0;
   end

   // R5
   lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> par_valid);

   // R5
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !par_valid);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(par_metrics));

   for (genvar k = 0; k < LABELS; k++) begin : g_lane_chk
      // R9
      pair_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $signed(par_metrics[k*METRIC_W +: METRIC_W]) ==
         -$signed(par_metrics[(LABELS-1-k)*METRIC_W +: METRIC_W]));

      // R2
      range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($signed(par_metrics[k*METRIC_W +: METRIC_W]) <= PEAK) &&
         ($signed(par_metrics[k*METRIC_W +: METRIC_W]) >= -PEAK));
   end

endmodule

// File: tb/softdec_branch_metric_tb.sv
`timescale 1ns/1ps
module softdec_branch_metric_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [8:0]  samples_i = '0;
   logic        par_valid;
   logic [39:0] par_metrics;
   logic        ser_valid;
   logic        ser_first;
   logic [7:0]  ser_bits;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [4:0] got [8];

   always #2.5 clk = ~clk;

   softdec_branch_metric dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .samples_i   (samples_i),
      .par_valid   (par_valid),
      .par_metrics (par_metrics),
      .ser_valid   (ser_valid),
      .ser_first   (ser_first),
      .ser_bits    (ser_bits)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int samp_val(logic [8:0] s, int j);
      int v;
      v = $signed(s[j*3 +: 3]);
      if (v == -4) v = -3;
      return v;
   endfunction

   function automatic int exp_metric(logic [8:0] s, int k);
      int acc = 0;
      for (int j = 0; j < 3; j++) begin
         if (((k >> (2 - j)) & 1) != 0) acc -= samp_val(s, j);
         else                           acc += samp_val(s, j);
      end
      return acc;
   endfunction

   function automatic int lane(int k);
      return $signed(par_metrics[k*5 +: 5]);
   endfunction

   task automatic check_par(input logic [8:0] s, input string req);
      for (int k = 0; k < 8; k++) begin
         chk(lane(k) == exp_metric(s, k), req, lane(k), exp_metric(s, k));
      end
   endtask

   // Called at the negedge right after the first serial bit was launched.
   task automatic grab_frame(input logic [8:0] s);
      chk(ser_first == 1'b1, "R7 first strobe", int'(ser_first), 1);
      for (int b = 0; b < 5; b++) begin
         chk(ser_valid == 1'b1, "R7 valid span", int'(ser_valid), 1);
         if (b > 0) chk(ser_first == 1'b0, "R7 first only once", int'(ser_first), 0);
         for (int l = 0; l < 8; l++) got[l][b] = ser_bits[l];
         if (b < 4) @(negedge clk);
      end
      for (int l = 0; l < 8; l++) begin
         chk($signed(got[l]) == exp_metric(s, l), "R7 serial lane",
             $signed(got[l]), exp_metric(s, l));
      end
   endtask

   task automatic send_and_check(input logic [8:0] s, input string req);
      @(negedge clk);
      in_valid  = 1'b1;
      samples_i = s;
      @(negedge clk);
      in_valid  = 1'b0;
      chk(par_valid == 1'b1, "R5 strobe", int'(par_valid), 1);
      check_par(s, req);
      @(negedge clk);
      chk(par_valid == 1'b0, "R5 one-cycle pulse", int'(par_valid), 0);
      grab_frame(s);
      @(negedge clk);
      chk(ser_valid == 1'b0, "R7 frame end", int'(ser_valid), 0);
   endtask

   initial begin
      logic [8:0] s;
      logic [8:0] a;
      logic [8:0] b;
      logic [39:0] held;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      // R1: during reset
      chk(par_valid == 1'b0 && ser_valid == 1'b0 && ser_first == 1'b0, "R1 strobes in reset",
          int'({par_valid, ser_valid, ser_first}), 0);
      chk(par_metrics == '0, "R1 metrics in reset", int'(par_metrics[31:0]), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(par_valid == 1'b0 && ser_valid == 1'b0, "R1 after reset",
          int'({par_valid, ser_valid}), 0);

      // R4: all samples -3
      send_and_check(9'b101_101_101, "R4 all -3");
      chk(lane(0) == -9, "R4 label 000", lane(0), -9);
      chk(lane(7) == 9, "R4 label 111", lane(7), 9);

      // R2: the -4 code behaves as -3
      send_and_check(9'b100_100_100, "R2 all -4");
      chk(lane(0) == -9, "R2 saturated 000", lane(0), -9);
      send_and_check(9'b011_100_001, "R2 mixed -4");

      // R3: label 010 gives i0 - i1 + i2 (i0=1, i1=2, i2=-1 -> -2)
      send_and_check({3'b111, 3'b010, 3'b001}, "R3 directed");
      chk(lane(2) == -2, "R3 label 010", lane(2), -2);

      // R10: exact-match pattern for every label
      for (int L = 0; L < 8; L++) begin
         s = '0;
         for (int j = 0; j < 3; j++) begin
            s[j*3 +: 3] = (((L >> (2 - j)) & 1) != 0) ? 3'b011 : 3'b101;
         end
         send_and_check(s, "R10 match pattern");
         chk(lane(L) == -9, "R10 matched label", lane(L), -9);
         for (int k = 0; k < 8; k++) begin
            if (k != L) chk(lane(k) > -9, "R10 others larger", lane(k), -8);
         end
      end

      // R3 / R9: random triples
      for (int r = 0; r < 40; r++) begin
         s = 9'($urandom);
         send_and_check(s, "R3 random");
         for (int k = 0; k < 4; k++) begin
            chk(lane(k) == -lane(7 - k), "R9 complement", lane(k), -lane(7 - k));
         end
      end

      // R6: samples with in_valid low are ignored
      held = par_metrics;
      for (int r = 0; r < 6; r++) begin
         @(negedge clk);
         samples_i = 9'($urandom);
         in_valid  = 1'b0;
      end
      @(negedge clk);
      chk(par_metrics == held, "R6 metrics held", int'(par_metrics[31:0]), int'(held[31:0]));
      chk(par_valid == 1'b0, "R6 no strobe", int'(par_valid), 0);

      // R8: second word arrives while the first frame is shifting
      a = 9'b001_110_011;
      b = 9'b111_011_101;
      @(negedge clk);
      in_valid = 1'b1; samples_i = a;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(ser_first == 1'b1, "R8 first frame started", int'(ser_first), 1);
      in_valid = 1'b1; samples_i = b;
      @(negedge clk);
      in_valid = 1'b0;
      chk(ser_first == 1'b0 && ser_valid == 1'b1, "R8 old frame bit1",
          int'({ser_first, ser_valid}), 1);
      chk(par_valid == 1'b1, "R8 new word strobe", int'(par_valid), 1);
      check_par(b, "R8 new word");
      @(negedge clk);
      grab_frame(b);
      @(negedge clk);
      chk(ser_valid == 1'b0, "R8 frame end", int'(ser_valid), 0);

      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule